// File: doc/BRIEF.md
# Legacy BIOS Shadow Region Router

This block steers memory transactions that fall in the upper legacy window just below 1 MB, from 0xC0000 up to 0xFFFFF. The window is split into thirteen shadow segments: twelve of 16 KB each, then one of 64 KB at the top. Each segment has a read-enable bit and a write-enable bit. These two bits choose, separately for each direction, whether an access lands in system DRAM or is sent on to the ROM/PCI side.

Firmware uses the two bits in different ways during boot. With reads sent to ROM and writes sent to DRAM, it can copy its own image into RAM. With reads served from DRAM and writes sent to ROM, it runs from the shadow copy, which is now write-protected. The other two combinations are also legal.

A simple write port loads both bits of one segment at a time. Each transaction presented with a valid strobe is decoded and gets a registered verdict one cycle later. The verdict holds a one-hot target select, a flag that marks the address as inside the window, the segment index, and the address itself. Addresses outside the window are not claimed by the block.

Top module: `shadow_router`

## Requirements
- R1: After reset every read-enable and write-enable bit is clear, so any access inside the window is routed to the ROM/PCI side.
- R2: Addresses 0xC0000 to 0xEFFFF form twelve 16 KB segments with index (address − 0xC0000) >> 14, giving values 0 to 11, and are reported with rsp_hit high.
- R3: Addresses 0xF0000 to 0xFFFFF form one 64 KB segment with index 12.
- R4: A read inside the window goes to DRAM (rsp_to_dram=1) when that segment's read-enable bit is 1, and to ROM/PCI (rsp_to_pci=1) when it is 0.
- R5: A write inside the window goes to DRAM when that segment's write-enable bit is 1, and to ROM/PCI otherwise. The read-enable bit plays no part in this, so all four combinations of the two bits route as stated in R4 and R5.
- R6: An address below 0xC0000 or at or above 0x100000 gives rsp_hit=0, both selects low and rsp_seg=0, and its address is passed unchanged on rsp_addr.
- R7: Every output is registered. A request with req_valid high at a clock edge shows up on the outputs after that edge with rsp_valid=1. With no valid request, rsp_valid, rsp_hit, both selects, rsp_seg and rsp_addr are all zero.
- R8: A configuration write takes effect at the clock edge that samples it. A request sampled at that same edge uses the old bits, and a request sampled at the next edge uses the new ones.
- R9: A configuration write whose segment index is 13 or more is ignored and changes no routing.
- R10: rsp_to_dram and rsp_to_pci are never high together, and exactly one of them is high when rsp_valid and rsp_hit are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_seg | input | SEG_W (4) | Segment index to configure |
| cfg_rd_en | input | 1 | New read-enable bit for that segment |
| cfg_wr_en | input | 1 | New write-enable bit for that segment |
| req_valid | input | 1 | Transaction valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (32) | Transaction byte address |
| rsp_valid | output | 1 | Verdict valid |
| rsp_hit | output | 1 | Address lies in the shadow window |
| rsp_to_dram | output | 1 | Route to system DRAM |
| rsp_to_pci | output | 1 | Route to ROM/PCI side |
| rsp_seg | output | SEG_W (4) | Segment index of the access |
| rsp_addr | output | ADDR_W (32) | Address passed through |

## Verification
The two functions that can fall in the same cycle are a configuration write and a transaction to the very segment being reconfigured. The bench provokes this in directed steps, for both a read and a write, and the random phase also hits it many times. It judges the result with a reference model that applies each write only after it has worked out the verdict for the request issued alongside it. So the request in the same cycle must show the old routing and the next request must show the new one.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_DRAM = 2'b01,
    TGT_PCI  = 2'b10
  } target_e;
endpackage

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SMALL_SEGS  = 12,
  parameter int unsigned SMALL_SHIFT = 14,
  parameter int unsigned WIN_BASE    = 32'h000C_0000,
  parameter int unsigned BIG_BASE    = 32'h000F_0000,
  parameter int unsigned WIN_LIMIT   = 32'h0010_0000,
  parameter int unsigned SEG_W       = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [SEG_W-1:0]  seg
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] BIG_A   = ADDR_W'(BIG_BASE);
  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(WIN_LIMIT);

  logic [ADDR_W-1:0] offset;
  logic              in_win;
  logic              in_big;

  always_comb begin
    offset = addr - BASE_A;
    in_win = (addr >= BASE_A) && (addr < LIMIT_A);
    in_big = in_win && (addr >= BIG_A);
    hit    = in_win;
    if (!in_win)
      seg = '0;
    else if (in_big)
      seg = SEG_W'(SMALL_SEGS);
    else
      seg = SEG_W'(offset >> SMALL_SHIFT);
  end
endmodule

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs #(
  parameter int unsigned NUM_SEGS = 13,
  parameter int unsigned SEG_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [SEG_W-1:0]    cfg_seg,
  input  logic                cfg_rd_en,
  input  logic                cfg_wr_en,
  output logic [NUM_SEGS-1:0] rd_en,
  output logic [NUM_SEGS-1:0] wr_en
);
  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_en[g] <= 1'b0;
        wr_en[g] <= 1'b0;
      end else if (cfg_we && (cfg_seg == SEG_W'(g))) begin
        rd_en[g] <= cfg_rd_en;
        wr_en[g] <= cfg_wr_en;
      end
    end
  end

  // R1: enable bits are clear right after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_en == '0) && (wr_en == '0));

  // R9: out-of-range segment writes leave the bits untouched
  a_r9_bad_seg_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_seg >= SEG_W'(NUM_SEGS))) |=> ($stable(rd_en) && $stable(wr_en)));
endmodule

// File: rtl/shadow_route_stage.sv
module shadow_route_stage
  import shadow_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_SEGS = 13,
  parameter int unsigned SEG_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                dec_hit,
  input  logic [SEG_W-1:0]    dec_seg,
  input  logic [NUM_SEGS-1:0] rd_en,
  input  logic [NUM_SEGS-1:0] wr_en,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_to_dram,
  output logic                rsp_to_pci,
  output logic [SEG_W-1:0]    rsp_seg,
  output logic [ADDR_W-1:0]   rsp_addr
);
  localparam int unsigned PAD = 1 << SEG_W;

  logic [PAD-1:0] rd_pad;
  logic [PAD-1:0] wr_pad;
  logic           use_dram;
  target_e        tgt;

  always_comb begin
    rd_pad   = PAD'(rd_en);
    wr_pad   = PAD'(wr_en);
    use_dram = req_write ? wr_pad[dec_seg] : rd_pad[dec_seg];
    if (!req_valid || !dec_hit)
      tgt = TGT_NONE;
    else if (use_dram)
      tgt = TGT_DRAM;
    else
      tgt = TGT_PCI;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_to_dram <= 1'b0;
      rsp_to_pci  <= 1'b0;
      rsp_seg     <= '0;
      rsp_addr    <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= req_valid && dec_hit;
      rsp_to_dram <= (tgt == TGT_DRAM);
      rsp_to_pci  <= (tgt == TGT_PCI);
      rsp_seg     <= (req_valid && dec_hit) ? dec_seg : '0;
      rsp_addr    <= req_valid ? req_addr : '0;
    end
  end

  // R10: never both targets
  a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_to_dram, rsp_to_pci}));

  // R10: claimed access picks exactly one target
  a_r10_one_target: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> $countones({rsp_to_dram, rsp_to_pci}) == 1);

  // R6: unclaimed access drives no target
  a_r6_outside_quiet: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (!rsp_to_dram && !rsp_to_pci && (rsp_seg == '0)));

  // R7: verdict follows a request by one cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  // R7: idle outputs stay quiet
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_to_dram && !rsp_to_pci));

  // R3: segment index never exceeds the top segment
  a_r3_seg_range: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_seg <= SEG_W'(NUM_SEGS - 1)));
endmodule

// File: rtl/shadow_router.sv
module shadow_router #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SMALL_SEGS  = 12,
  parameter int unsigned SMALL_SHIFT = 14,
  parameter int unsigned WIN_BASE    = 32'h000C_0000,
  parameter int unsigned BIG_BASE    = 32'h000F_0000,
  parameter int unsigned WIN_LIMIT   = 32'h0010_0000,
  localparam int unsigned NUM_SEGS   = SMALL_SEGS + 1,
  localparam int unsigned SEG_W      = $clog2(NUM_SEGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_seg,
  input  logic              cfg_rd_en,
  input  logic              cfg_wr_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_to_dram,
  output logic              rsp_to_pci,
  output logic [SEG_W-1:0]  rsp_seg,
  output logic [ADDR_W-1:0] rsp_addr
);
  logic                dec_hit;
  logic [SEG_W-1:0]    dec_seg;
  logic [NUM_SEGS-1:0] rd_en;
  logic [NUM_SEGS-1:0] wr_en;

  shadow_seg_decode #(
    .ADDR_W(ADDR_W), .SMALL_SEGS(SMALL_SEGS), .SMALL_SHIFT(SMALL_SHIFT),
    .WIN_BASE(WIN_BASE), .BIG_BASE(BIG_BASE), .WIN_LIMIT(WIN_LIMIT), .SEG_W(SEG_W)
  ) i_decode (
    .addr(req_addr), .hit(dec_hit), .seg(dec_seg)
  );

  shadow_cfg_regs #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) i_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
    .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en),
    .rd_en(rd_en), .wr_en(wr_en)
  );

  shadow_route_stage #(.ADDR_W(ADDR_W), .NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) i_route (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .dec_hit(dec_hit), .dec_seg(dec_seg),
    .rd_en(rd_en), .wr_en(wr_en),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_to_dram(rsp_to_dram),
    .rsp_to_pci(rsp_to_pci), .rsp_seg(rsp_seg), .rsp_addr(rsp_addr)
  );

  // R2: the address echoed back belongs to a claimed window when hit is set
  a_r2_hit_in_window: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> ((rsp_addr >= ADDR_W'(WIN_BASE)) && (rsp_addr < ADDR_W'(WIN_LIMIT))));
endmodule

// File: tb/test_shadow_router.sv
module test_shadow_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_seg = '0;
  logic        cfg_rd_en = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_to_dram, rsp_to_pci;
  logic [3:0]  rsp_seg;
  logic [31:0] rsp_addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic mdl_rd [13];
  logic mdl_wr [13];
  logic [39:0] exp_vec = '0;
  string exp_tag = "R7";

  always #4 clk = ~clk;

  shadow_router i_shadow_router (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
    .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_to_dram(rsp_to_dram), .rsp_to_pci(rsp_to_pci),
    .rsp_seg(rsp_seg), .rsp_addr(rsp_addr)
  );

  function automatic logic [39:0] expect_of(logic v, logic [31:0] a, logic w);
    logic hit, dram;
    logic [3:0] seg;
    hit = v && (a >= 32'hC0000) && (a < 32'h100000);
    seg = 4'd0;
    if (hit) seg = (a >= 32'hF0000) ? 4'd12 : 4'((a - 32'hC0000) >> 14);
    dram = hit && (w ? mdl_wr[seg] : mdl_rd[seg]);
    return {v, hit, dram, hit && !dram, seg, (v ? a : 32'h0)};
  endfunction

  task automatic check_pending();
    logic [39:0] got;
    got = {rsp_valid, rsp_hit, rsp_to_dram, rsp_to_pci, rsp_seg, rsp_addr};
    total++;
    if (got !== exp_vec) begin
      bad++;
      $display("FAIL %s: got v=%b hit=%b dram=%b pci=%b seg=%0d addr=%h expected v=%b hit=%b dram=%b pci=%b seg=%0d addr=%h",
               exp_tag, got[39], got[38], got[37], got[36], got[35:32], got[31:0],
               exp_vec[39], exp_vec[38], exp_vec[37], exp_vec[36], exp_vec[35:32], exp_vec[31:0]);
    end
  endtask

  task automatic cyc(input logic v, input logic [31:0] a, input logic w,
                     input logic cw, input logic [3:0] cs, input logic cr,
                     input logic cwe, input string tag);
    @(negedge clk);
    check_pending();
    req_valid = v; req_addr = a; req_write = w;
    cfg_we = cw; cfg_seg = cs; cfg_rd_en = cr; cfg_wr_en = cwe;
    exp_vec = expect_of(v, a, w);
    exp_tag = tag;
    if (cw && cs < 4'd13) begin
      mdl_rd[cs] = cr;
      mdl_wr[cs] = cwe;
    end
  endtask

  task automatic acc(input logic [31:0] a, input logic w, input string tag);
    cyc(1'b1, a, w, 1'b0, 4'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic cfg(input logic [3:0] s, input logic r, input logic w);
    cyc(1'b0, 32'h0, 1'b0, 1'b1, s, r, w, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R7: watchdog expired, got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    for (int i = 0; i < 13; i++) begin mdl_rd[i] = 1'b0; mdl_wr[i] = 1'b0; end
    sd = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R7: reset state of the outputs, then idle cycle
    cyc(1'b0, 32'h0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, "R7");
    // R1: every segment routes to ROM/PCI after reset, both directions
    for (int s = 0; s < 13; s++) begin
      acc(32'hC0000 + (s * 32'h4000), 1'b0, "R1");
      acc(32'hC0000 + (s * 32'h4000) + 32'h10, 1'b1, "R1");
    end
    // R2 / R3 boundaries
    acc(32'hC0000, 1'b0, "R2");
    acc(32'hC3FFF, 1'b0, "R2");
    acc(32'hC4000, 1'b1, "R2");
    acc(32'hEFFFF, 1'b0, "R2");
    acc(32'hF0000, 1'b0, "R3");
    acc(32'hF8000, 1'b1, "R3");
    acc(32'hFFFFF, 1'b0, "R3");
    // R6: just outside on both sides
    acc(32'hBFFFF, 1'b0, "R6");
    acc(32'h100000, 1'b1, "R6");
    acc(32'h0, 1'b0, "R6");
    acc(32'hFFFF_FFFF, 1'b1, "R6");
    // R4 / R5: all four combinations on segment 5
    for (int m = 0; m < 4; m++) begin
      cfg(4'd5, m[0], m[1]);
      acc(32'hD4000, 1'b0, "R4");
      acc(32'hD7FFC, 1'b1, "R5");
    end
    // R8: write and access to the same segment in one cycle
    cfg(4'd3, 1'b0, 1'b0);
    cyc(1'b1, 32'hCC100, 1'b0, 1'b1, 4'd3, 1'b1, 1'b1, "R8");
    acc(32'hCC100, 1'b0, "R8");
    cyc(1'b1, 32'hCC200, 1'b1, 1'b1, 4'd3, 1'b0, 1'b0, "R8");
    acc(32'hCC200, 1'b1, "R8");
    // R3: large segment copy mode then run mode
    cfg(4'd12, 1'b0, 1'b1);
    acc(32'hF1234, 1'b0, "R3");
    acc(32'hF1234, 1'b1, "R3");
    cfg(4'd12, 1'b1, 1'b0);
    acc(32'hFEEEE, 1'b0, "R3");
    acc(32'hFEEEE, 1'b1, "R3");
    // R9: illegal indices must not change any segment
    for (int s = 0; s < 13; s++) cfg(4'(s), 1'b0, 1'b0);
    cfg(4'd13, 1'b1, 1'b1);
    cfg(4'd15, 1'b1, 1'b1);
    for (int s = 0; s < 13; s++) begin
      acc(32'hC0000 + (s * 32'h4000) + 32'h20, 1'b0, "R9");
      acc(32'hC0000 + (s * 32'h4000) + 32'h24, 1'b1, "R9");
    end

    // random phase, R10 judged on every verdict
    for (int n = 0; n < 3000; n++) begin
      int unsigned k;
      logic [31:0] a;
      logic v, w, cw;
      string tg;
      k = $urandom % 8;
      if (k < 6)       a = 32'hC0000 + ($urandom % 32'h40000);
      else if (k == 6) a = $urandom % 32'hC0000;
      else             a = 32'h100000 + ($urandom % 32'h100_0000);
      v  = ($urandom % 8) != 0;
      w  = $urandom % 2;
      cw = ($urandom % 10) < 3;
      if (!v)                                tg = "R7";
      else if (a < 32'hC0000 || a >= 32'h100000) tg = "R6";
      else if (w)                            tg = "R5";
      else                                   tg = "R4";
      if (cw) tg = {tg, "/R8/R10"};
      cyc(v, a, w, cw, 4'($urandom % 16), 1'($urandom % 2), 1'($urandom % 2), tg);
    end
    cyc(1'b0, 32'h0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, "R7");
    @(negedge clk);
    check_pending();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule